// File: doc/BRIEF.md
# Lite Timer with Timebase, Auto-Reload Channel and Edge Capture

This block is a small timer peripheral on an 8-bit register bus. A free-running 8-bit counter advances on every oscillator clock. A prescaled timebase channel raises a flag, and optionally an interrupt, each time its period expires. Software picks one of two periods with a control bit. A second channel counts up from a software-loaded reload value to FFh, reloads, and flags each wrap.

An input capture channel watches an asynchronous pin. The pin passes through a two-stage synchronizer. Any change on it, rising or falling, copies the free-running counter into a read-only capture register. A capture happens only while the capture flag is clear, so an unread capture is never overwritten.

Flags clear when software reads them: the timebase flag clears on a read of the main status register, the capture flag on a read of the capture register, and the reload flag on a read of the auxiliary status register. Reads present data combinationally from the address. The read strobe only triggers these clear side effects, which take effect at the next clock edge.

Top module: `lite_tick_timer`

## Requirements
- R1: After reset, every mapped register (08h, 09h, 0Ah, 0Bh, 0Ch) reads 00h and all three interrupt outputs are low.
- R2: The counter at 0Ah rises by one on every clock, wraps from FFh to 00h, and ignores bus writes. It reads N after the N-th clock edge following reset release.
- R3: The timebase flag is set once every PER_SHORT clocks while bit 5 of 0Bh is 0, and once every PER_LONG clocks while it is 1. The defaults are 8000 and 16000.
- R4: The timebase flag is bit 3 of 0Bh. A read strobe at 0Bh clears it at the next edge. If it is set at that same edge, the set wins. Bus writes never change it.
- R5: The capture input is synchronized through two flops, and either edge on it triggers a capture. If the input changes in the cycle where 0Ah reads k, then 0Ch receives k+2 (mod 256) and bit 6 of 0Bh (the capture flag) sets.
- R6: While the capture flag is set, further input edges leave 0Ch unchanged. A read strobe at 0Ch clears the flag. A read of 0Bh does not clear it.
- R7: 09h is a read/write reload value R. The reload flag (bit 0 of 08h) is set once every 256-R clocks, and a read strobe at 08h clears it.
- R8: Each interrupt output is high exactly when its flag and its enable are both set. The enables are: bit 4 of 0Bh for the timebase, bit 7 of 0Bh for capture, and bit 1 of 08h for the reload channel.
- R9: These locations always read 0:
  - bits 2:0 of 0Bh;
  - bits 7:2 of 08h;
  - any address other than 08h–0Ch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rstN | input | 1 | Asynchronous active-low reset |
| addr | input | 8 | Register address |
| wrData | input | 8 | Write data |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe (triggers read-clear side effects) |
| rdData | output | 8 | Read data for the addressed register |
| capIn | input | 1 | Asynchronous capture input |
| irqTimebase | output | 1 | Timebase interrupt request |
| irqCapture | output | 1 | Capture interrupt request |
| irqReload | output | 1 | Reload-channel interrupt request |

## Verification
The hardest case to reach from the ports is an edge on the capture pin while the capture flag is still set. The bench handles this with a pulse on the pin after every capture, which makes two edges that must both be ignored. The next capture therefore uses the opposite pin polarity, so rising and falling captures alternate across the sweep.

A second hard case is a read-clear landing on the same edge as a timebase set. The bench computes the tick grid from the measured period and issues the read exactly one cycle before a tick.

// File: rtl/ltt_pkg.sv
`timescale 1ns/1ps
package ltt_pkg;
  localparam int DATA_W = 8;

  localparam logic [7:0] REG_AUX    = 8'h08;
  localparam logic [7:0] REG_RELOAD = 8'h09;
  localparam logic [7:0] REG_COUNT  = 8'h0A;
  localparam logic [7:0] REG_MAIN   = 8'h0B;
  localparam logic [7:0] REG_CAPT   = 8'h0C;

  typedef struct packed {
    logic arrLoad;
    logic tbClr;
    logic capClr;
    logic rlClr;
  } ltt_strobe_t;

  typedef struct packed {
    logic              tbFlag;
    logic              capFlag;
    logic              rlFlag;
    logic [DATA_W-1:0] freeCnt;
    logic [DATA_W-1:0] capVal;
    logic [DATA_W-1:0] arr;
  } ltt_status_t;
endpackage

// File: rtl/ltt_dpath.sv
`timescale 1ns/1ps
module ltt_dpath import ltt_pkg::*; #(
  parameter int PER_SHORT   = 8000,
  parameter int PER_LONG    = 16000,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              capIn,
  input  logic              longSel,
  input  logic [DATA_W-1:0] wrData,
  input  ltt_strobe_t       strobe,
  output ltt_status_t       status
);
  localparam int TBW = $clog2(PER_LONG + 1);
  localparam logic [TBW-1:0] LAST_SHORT = TBW'(PER_SHORT - 1);
  localparam logic [TBW-1:0] LAST_LONG  = TBW'(PER_LONG - 1);

  logic [DATA_W-1:0] freeCnt, capVal, arr, rlCnt;
  logic [TBW-1:0]    tbCnt;
  logic              tbTick, tbFlag, capFlag, rlFlag, rlWrap, edgeDet;
  logic [SYNC_STAGES:0] syncReg;

  // free-running counter
  always_ff @(posedge clk or negedge rstN)
    if (!rstN) freeCnt <= '0;
    else       freeCnt <= freeCnt + 1'b1;

  // prescaled timebase
  assign tbTick = (tbCnt >= (longSel ? LAST_LONG : LAST_SHORT));

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      tbCnt  <= '0;
      tbFlag <= 1'b0;
    end else begin
      tbCnt  <= tbTick ? '0 : tbCnt + 1'b1;
      tbFlag <= tbTick | (tbFlag & ~strobe.tbClr);
    end

  // capture synchronizer and edge detector
  always_ff @(posedge clk or negedge rstN)
    if (!rstN) syncReg <= '0;
    else       syncReg <= {syncReg[SYNC_STAGES-1:0], capIn};

  assign edgeDet = syncReg[SYNC_STAGES] ^ syncReg[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      capVal  <= '0;
      capFlag <= 1'b0;
    end else if (edgeDet && !capFlag) begin
      capVal  <= freeCnt;
      capFlag <= 1'b1;
    end else if (strobe.capClr) begin
      capFlag <= 1'b0;
    end

  // auto-reload channel
  assign rlWrap = (rlCnt == '1);

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      arr    <= '0;
      rlCnt  <= '0;
      rlFlag <= 1'b0;
    end else begin
      if (strobe.arrLoad) arr <= wrData;
      rlCnt  <= rlWrap ? arr : rlCnt + 1'b1;
      rlFlag <= rlWrap | (rlFlag & ~strobe.rlClr);
    end

  assign status = '{tbFlag: tbFlag, capFlag: capFlag, rlFlag: rlFlag,
                    freeCnt: freeCnt, capVal: capVal, arr: arr};

  AST_FREE_INC: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> freeCnt == $past(freeCnt) + 8'd1); // R2
  AST_TB_SET: assert property (@(posedge clk) disable iff (!rstN)
    tbTick |=> tbFlag); // R3
  AST_TB_CLR: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.tbClr && !tbTick) |=> !tbFlag); // R4
  AST_CAP_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (edgeDet && !capFlag) |=> (capFlag && capVal == $past(freeCnt))); // R5
  AST_CAP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    capFlag |=> $stable(capVal)); // R6
  AST_RL_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    rlWrap |=> (rlFlag && rlCnt == $past(arr))); // R7
endmodule

// File: rtl/ltt_ctrl.sv
`timescale 1ns/1ps
module ltt_ctrl import ltt_pkg::*; (
  input  logic              clk,
  input  logic              rstN,
  input  logic [7:0]        addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrEn,
  input  logic              rdEn,
  input  ltt_status_t       status,
  output ltt_strobe_t       strobe,
  output logic              longSel,
  output logic [DATA_W-1:0] rdData,
  output logic              irqTimebase,
  output logic              irqCapture,
  output logic              irqReload
);
  logic capIe, tbIe, rlIe;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      capIe   <= 1'b0;
      longSel <= 1'b0;
      tbIe    <= 1'b0;
      rlIe    <= 1'b0;
    end else if (wrEn) begin
      if (addr == REG_MAIN) begin
        capIe   <= wrData[7];
        longSel <= wrData[5];
        tbIe    <= wrData[4];
      end
      if (addr == REG_AUX) rlIe <= wrData[1];
    end

  always_comb begin
    strobe.arrLoad = wrEn && (addr == REG_RELOAD);
    strobe.tbClr   = rdEn && (addr == REG_MAIN);
    strobe.capClr  = rdEn && (addr == REG_CAPT);
    strobe.rlClr   = rdEn && (addr == REG_AUX);
  end

  always_comb begin
    case (addr)
      REG_AUX:    rdData = {6'b0, rlIe, status.rlFlag};
      REG_RELOAD: rdData = status.arr;
      REG_COUNT:  rdData = status.freeCnt;
      REG_MAIN:   rdData = {capIe, status.capFlag, longSel, tbIe, status.tbFlag, 3'b000};
      REG_CAPT:   rdData = status.capVal;
      default:    rdData = '0;
    endcase
  end

  assign irqTimebase = status.tbFlag  & tbIe;
  assign irqCapture  = status.capFlag & capIe;
  assign irqReload   = status.rlFlag  & rlIe;

  AST_CFG_WR: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == REG_MAIN) |=> (longSel == $past(wrData[5]))); // R3
  AST_IRQ_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == REG_MAIN && !wrData[4]) |=> !irqTimebase); // R8
endmodule

// File: rtl/lite_tick_timer.sv
`timescale 1ns/1ps
module lite_tick_timer import ltt_pkg::*; #(
  parameter int PER_SHORT = 8000,
  parameter int PER_LONG  = 16000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] addr,
  input  logic [7:0] wrData,
  input  logic       wrEn,
  input  logic       rdEn,
  output logic [7:0] rdData,
  input  logic       capIn,
  output logic       irqTimebase,
  output logic       irqCapture,
  output logic       irqReload
);
  ltt_strobe_t strobe;
  ltt_status_t status;
  logic        longSel;

  ltt_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .addr(addr), .wrData(wrData), .wrEn(wrEn), .rdEn(rdEn),
    .status(status), .strobe(strobe), .longSel(longSel), .rdData(rdData),
    .irqTimebase(irqTimebase), .irqCapture(irqCapture), .irqReload(irqReload)
  );

  ltt_dpath #(.PER_SHORT(PER_SHORT), .PER_LONG(PER_LONG), .SYNC_STAGES(2)) u_dpath (
    .clk(clk), .rstN(rstN), .capIn(capIn), .longSel(longSel), .wrData(wrData),
    .strobe(strobe), .status(status)
  );
endmodule

// File: tb/lite_tick_timer_test.sv
`timescale 1ns/1ps
module lite_tick_timer_test;
  localparam int PS = 20;
  localparam int PL = 40;

  logic clk = 1'b0, rstN = 1'b0, wrEn = 1'b0, rdEn = 1'b0, capIn = 1'b0;
  logic [7:0] addr = 8'h00, wrData = 8'h00, rdData;
  logic irqTimebase, irqCapture, irqReload;
  int   cyc = 0, nChk = 0, nFail = 0;

  lite_tick_timer #(.PER_SHORT(PS), .PER_LONG(PL)) uut (
    .clk(clk), .rstN(rstN), .addr(addr), .wrData(wrData), .wrEn(wrEn), .rdEn(rdEn),
    .rdData(rdData), .capIn(capIn), .irqTimebase(irqTimebase), .irqCapture(irqCapture),
    .irqReload(irqReload)
  );

  always #4 clk = ~clk;
  always @(posedge clk) if (rstN) cyc <= cyc + 1;

  task automatic chk(input string req, input int act, input int exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic peek(input logic [7:0] a, output logic [7:0] d);
    addr = a; #1; d = rdData;
  endtask

  task automatic busRead(input logic [7:0] a);
    addr = a; rdEn = 1'b1; @(negedge clk); rdEn = 1'b0;
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [7:0] d);
    addr = a; wrData = d; wrEn = 1'b1; @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic waitFlag(input logic [7:0] a, input int bitIdx, output int at);
    logic [7:0] d;
    at = -1;
    for (int i = 0; i < 2000; i++) begin
      peek(a, d);
      if (d[bitIdx]) begin at = cyc; break; end
      @(negedge clk);
    end
    if (at < 0) chk("flag-timeout", 0, 1);
  endtask

  initial begin
    #(8 * 150000);
    nFail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  == %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int t1, t2, t3, k;
    logic [7:0] rl [6];
    rl = '{8'hF0, 8'hE0, 8'hC0, 8'h80, 8'h00, 8'hFE};

    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    for (int a = 8; a <= 12; a++) begin
      peek(8'(a), d);
      chk(a == 10 ? "R1 count" : "R1", int'(d), (a == 10) ? cyc % 256 : 0);
    end
    chk("R1 irq", {irqTimebase, irqCapture, irqReload}, 0);

    // R2 counter sweep with wrap, writes ignored
    for (int i = 0; i < 300; i++) begin
      peek(8'h0A, d); chk("R2", int'(d), cyc % 256);
      if (i % 50 == 7) busWrite(8'h0A, 8'h55); else @(negedge clk);
    end

    // R3/R4 short period and read-clear
    busRead(8'h0B);
    waitFlag(8'h0B, 3, t1);
    chk("R3 grid", t1 % PS, 0);
    busRead(8'h0B);
    peek(8'h0B, d); chk("R4 cleared", int'(d[3]), 0);
    busWrite(8'h0B, 8'h08);
    peek(8'h0B, d); chk("R4 write-ignored", int'(d[3]), 0);
    waitFlag(8'h0B, 3, t2);
    chk("R3 short", t2 - t1, PS);
    busWrite(8'h0B, 8'h00); peek(8'h0B, d); chk("R4 write keeps", int'(d[3]), 1);

    // R3 long period
    busWrite(8'h0B, 8'h20);
    busRead(8'h0B); waitFlag(8'h0B, 3, t1);
    busRead(8'h0B); waitFlag(8'h0B, 3, t2);
    busRead(8'h0B); waitFlag(8'h0B, 3, t3);
    chk("R3 long", t2 - t1, PL);
    chk("R3 long", t3 - t2, PL);
    // R4 set wins over simultaneous clear
    busRead(8'h0B);
    while (cyc != t3 + PL - 1) @(negedge clk);
    busRead(8'h0B);
    peek(8'h0B, d); chk("R4 set-wins", int'(d[3]), 1);

    // R8 timebase interrupt gating
    busWrite(8'h0B, 8'h10); #1; chk("R8 tb on", int'(irqTimebase), 1);
    busWrite(8'h0B, 8'h00); #1; chk("R8 tb off", int'(irqTimebase), 0);

    // R9 reserved bits and unmapped addresses
    busWrite(8'h0B, 8'hFF); peek(8'h0B, d); chk("R9 main", int'(d & 8'hB7), 8'hB0);
    busWrite(8'h08, 8'hFF); peek(8'h08, d); chk("R9 aux", int'(d & 8'hFE), 8'h02);
    for (int a = 0; a < 32; a++)
      if (a < 8 || a > 12) begin peek(8'(a), d); chk("R9 unmapped", int'(d), 0); end
    busWrite(8'h0B, 8'h00); busWrite(8'h08, 8'h00);
    busRead(8'h0C);

    // R5/R6/R8 capture sweep, alternating edge polarity
    for (int i = 0; i < 40; i++) begin
      busWrite(8'h0B, (i % 2) ? 8'h80 : 8'h00);
      repeat (i % 7) @(negedge clk);
      k = cyc; capIn = ~capIn;
      repeat (4) @(negedge clk);
      peek(8'h0C, d); chk("R5 value", int'(d), (k + 2) % 256);
      peek(8'h0B, d); chk("R5 flag", int'(d[6]), 1);
      chk("R8 cap", int'(irqCapture), i % 2);
      capIn = ~capIn; repeat (3) @(negedge clk);
      capIn = ~capIn; repeat (4) @(negedge clk);
      peek(8'h0C, d); chk("R6 hold", int'(d), (k + 2) % 256);
      busRead(8'h0B);
      peek(8'h0B, d); chk("R6 main-read", int'(d[6]), 1);
      busRead(8'h0C);
      peek(8'h0B, d); chk("R6 clear", int'(d[6]), 0);
    end
    busWrite(8'h0B, 8'h00);

    // R7/R8 reload channel
    foreach (rl[j]) begin
      busWrite(8'h09, rl[j]);
      peek(8'h09, d); chk("R7 reload reg", int'(d), int'(rl[j]));
      busRead(8'h08); waitFlag(8'h08, 0, t1);
      busRead(8'h08);
      if (rl[j] != 8'hFE) begin peek(8'h08, d); chk("R7 cleared", int'(d[0]), 0); end
      waitFlag(8'h08, 0, t2);
      busRead(8'h08); waitFlag(8'h08, 0, t3);
      chk("R7 period", t3 - t2, 256 - int'(rl[j]));
      busWrite(8'h08, 8'h02); #1; chk("R8 reload", int'(irqReload), 1);
      busWrite(8'h08, 8'h00); #1; chk("R8 reload off", int'(irqReload), 0);
    end

    $display("  == %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end
endmodule